// File: doc/BRIEF.md
# Spike-Timing Plasticity Queue Engine

This block adjusts synaptic weights from the relative timing of spikes. It watches presynaptic events (a source neuron firing into the connection table) and postsynaptic events (a target neuron firing out of the neuron array). It keeps a short history of each kind in two timed queues. Every entry carries a countdown value that one global decay tick lowers by one. A presynaptic entry starts at `TAU_PLUS` and a postsynaptic entry starts at `TAU_MINUS`, with `TAU_PLUS < TAU_MINUS` so that learning stays stable.

A postsynaptic spike is matched against every live presynaptic entry, and each match raises that synapse's weight by the entry's remaining value (causal potentiation). A presynaptic spike is matched against every live postsynaptic entry, and each match lowers the weight by the entry's remaining value (anti-causal depression). The update therefore shrinks linearly with the separation in decay ticks. The engine applies the updates one queue slot per clock through a single read-modify-write port into an external weight table. While a scan runs, new events are held off by a ready signal. The weight table lives outside the block and its plastic weights are normally seeded at 8.

Top module: `stdp_tq_engine`

## Requirements
- R1: During and directly after reset `rdy_o` is 1, `tbl_req_o` and `tbl_we_o` are 0, and both queues are empty, so a first event causes no table write.
- R2: An accepted presynaptic event stores its address with value `TAU_PLUS`, and an accepted postsynaptic event stores its address with value `TAU_MINUS`. Each accepted tick lowers every nonzero value in both queues by one. A slot whose value is 0 is empty and is never matched.
- R3: For an accepted postsynaptic event with address d, each presynaptic slot holding address s and value v>0 requests the table with `tbl_src_o`=s and `tbl_dst_o`=d. The weight is then written back as the old weight plus v.
- R4: For an accepted presynaptic event with address s, each postsynaptic slot holding address d and value v>0 requests the table with `tbl_src_o`=s and `tbl_dst_o`=d. The weight is then written back as the old weight minus v.
- R5: Written weights saturate at 0 and at 2^`W_W`-1 (31 by default) and never wrap.
- R6: When `tbl_hit_i` is 0 for a requested pair (no synapse row), nothing is written and that weight is unchanged.
- R7: Each queue holds `DEPTH` slots. A push into a full queue overwrites the oldest entry.
- R8: An accepted pre or post event holds `rdy_o` at 0 for exactly `DEPTH` cycles and scans one slot per clock. An accepted tick takes one cycle and leaves `rdy_o` at 1. Inputs are taken only while `rdy_o` is 1, and they are held by the sender until taken.
- R9: When several valids are high together, the tick is taken first, then the post event, then the pre event. An event is matched against the opposite queue as it stood before that event's own push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_vld_i | input | 1 | Global decay tick request |
| post_vld_i | input | 1 | Postsynaptic event request |
| post_addr_i | input | ADDR_W | Address of the firing target neuron |
| pre_vld_i | input | 1 | Presynaptic event request |
| pre_addr_i | input | ADDR_W | Address of the firing source neuron |
| rdy_o | output | 1 | Engine idle; a held request is taken at this edge |
| tbl_req_o | output | 1 | Table access for the current slot |
| tbl_src_o | output | ADDR_W | Source (pre) neuron of the addressed synapse |
| tbl_dst_o | output | ADDR_W | Target (post) neuron of the addressed synapse |
| tbl_rdata_i | input | W_W | Current weight, returned in the same cycle |
| tbl_hit_i | input | 1 | Synapse row exists for the requested pair |
| tbl_we_o | output | 1 | Write the updated weight this cycle |
| tbl_wdata_o | output | W_W | Saturated updated weight |

## Verification
The assertions assume that the table answers a request in the same cycle with a stable weight and hit flag. They also assume that a requester keeps its valid high until `rdy_o` takes it. The bench models the table as a combinational array and drives every request through one task. That task raises the valids only when `rdy_o` is 1 and drops each one at the falling edge after its acceptance, so no valid is lost or counted twice. Random traffic mixes ticks, pre and post events with a sparse pattern of missing rows. Directed cases push weights into both saturation limits and overflow a queue.

// File: rtl/stdp_tq_pkg.sv
package stdp_tq_pkg;

    localparam int DEF_ADDR_W    = 3;
    localparam int DEF_W_W       = 5;
    localparam int DEF_DEPTH     = 4;
    localparam int DEF_TAU_PLUS  = 3;
    localparam int DEF_TAU_MINUS = 5;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_POST_EV = 2'd1,
        ST_PRE_EV  = 2'd2
    } scan_st_e;

    function automatic int cnt_width(input int tau_max);
        return $clog2(tau_max + 1);
    endfunction

endpackage

// File: rtl/stdp_tq_queue.sv
module stdp_tq_queue #(
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 3,
    parameter int DEPTH  = 4,
    parameter int INIT   = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push_i,
    input  logic [ADDR_W-1:0]        push_addr_i,
    input  logic                     tick_i,
    input  logic [$clog2(DEPTH)-1:0] rd_idx_i,
    output logic [ADDR_W-1:0]        rd_addr_o,
    output logic [CNT_W-1:0]         rd_cnt_o
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic [ADDR_W-1:0] slot_addr [DEPTH];
    logic [CNT_W-1:0]  slot_cnt  [DEPTH];
    logic [IDX_W-1:0]  wr_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                slot_cnt[i]  <= '0;
                slot_addr[i] <= '0;
            end
        end else begin
            if (tick_i) begin
                for (int i = 0; i < DEPTH; i++)
                    if (slot_cnt[i] != '0)
                        slot_cnt[i] <= slot_cnt[i] - 1'b1;
            end
            if (push_i) begin
                slot_cnt[wr_ptr]  <= CNT_W'(INIT);
                slot_addr[wr_ptr] <= push_addr_i;
                wr_ptr            <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
        end
    end

    assign rd_addr_o = slot_addr[rd_idx_i];
    assign rd_cnt_o  = slot_cnt[rd_idx_i];

    for (genvar g = 0; g < DEPTH; g++) begin : g_chk
        // R2
        cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
            slot_cnt[g] <= CNT_W'(INIT));
        // R2
        tick_step_chk: assert property (@(posedge clk) disable iff (rst)
            (tick_i && !push_i && slot_cnt[g] != '0) |=> slot_cnt[g] == $past(slot_cnt[g]) - 1'b1);
    end

endmodule

// File: rtl/stdp_tq_update.sv
module stdp_tq_update #(
    parameter int W_W   = 5,
    parameter int CNT_W = 3
) (
    input  logic [W_W-1:0]   w_i,
    input  logic [CNT_W-1:0] amt_i,
    input  logic             up_i,
    output logic [W_W-1:0]   w_o
);
    localparam int SW = (W_W > CNT_W ? W_W : CNT_W) + 1;
    localparam logic [SW-1:0] W_MAX = SW'((1 << W_W) - 1);

    logic [SW-1:0] w_ext, a_ext, sum;

    always_comb begin
        w_ext = SW'(w_i);
        a_ext = SW'(amt_i);
        sum   = w_ext + a_ext;
        if (up_i)
            w_o = (sum > W_MAX) ? W_W'(W_MAX) : W_W'(sum);
        else
            w_o = (a_ext >= w_ext) ? '0 : W_W'(w_ext - a_ext);
    end

endmodule

// File: rtl/stdp_tq_engine.sv
module stdp_tq_engine
    import stdp_tq_pkg::*;
#(
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int W_W       = DEF_W_W,
    parameter int DEPTH     = DEF_DEPTH,
    parameter int TAU_PLUS  = DEF_TAU_PLUS,
    parameter int TAU_MINUS = DEF_TAU_MINUS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_vld_i,
    input  logic              post_vld_i,
    input  logic [ADDR_W-1:0] post_addr_i,
    input  logic              pre_vld_i,
    input  logic [ADDR_W-1:0] pre_addr_i,
    output logic              rdy_o,
    output logic              tbl_req_o,
    output logic [ADDR_W-1:0] tbl_src_o,
    output logic [ADDR_W-1:0] tbl_dst_o,
    input  logic [W_W-1:0]    tbl_rdata_i,
    input  logic              tbl_hit_i,
    output logic              tbl_we_o,
    output logic [W_W-1:0]    tbl_wdata_o
);
    localparam int CNT_W = cnt_width(TAU_MINUS > TAU_PLUS ? TAU_MINUS : TAU_PLUS);
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    scan_st_e          st;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] ev_addr;

    logic tick_acc, post_acc, pre_acc, last_slot;
    logic [ADDR_W-1:0] pre_q_addr, post_q_addr;
    logic [CNT_W-1:0]  pre_q_cnt, post_q_cnt, amt;
    logic              causal;

    assign rdy_o     = (st == ST_IDLE);
    assign tick_acc  = rdy_o && tick_vld_i;
    assign post_acc  = rdy_o && !tick_vld_i && post_vld_i;
    assign pre_acc   = rdy_o && !tick_vld_i && !post_vld_i && pre_vld_i;
    assign last_slot = (idx == LAST);
    assign causal    = (st == ST_POST_EV);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            idx     <= '0;
            ev_addr <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    idx <= '0;
                    if (post_acc) begin
                        st      <= ST_POST_EV;
                        ev_addr <= post_addr_i;
                    end else if (pre_acc) begin
                        st      <= ST_PRE_EV;
                        ev_addr <= pre_addr_i;
                    end
                end
                ST_POST_EV, ST_PRE_EV: begin
                    idx <= idx + 1'b1;
                    if (last_slot) begin
                        st  <= ST_IDLE;
                        idx <= '0;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    stdp_tq_queue #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH(DEPTH), .INIT(TAU_PLUS)
    ) pre_q_i (
        .clk(clk), .rst(rst),
        .push_i(st == ST_PRE_EV && last_slot), .push_addr_i(ev_addr),
        .tick_i(tick_acc), .rd_idx_i(idx),
        .rd_addr_o(pre_q_addr), .rd_cnt_o(pre_q_cnt)
    );

    stdp_tq_queue #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH(DEPTH), .INIT(TAU_MINUS)
    ) post_q_i (
        .clk(clk), .rst(rst),
        .push_i(st == ST_POST_EV && last_slot), .push_addr_i(ev_addr),
        .tick_i(tick_acc), .rd_idx_i(idx),
        .rd_addr_o(post_q_addr), .rd_cnt_o(post_q_cnt)
    );

    assign amt       = causal ? pre_q_cnt : post_q_cnt;
    assign tbl_req_o = (causal && pre_q_cnt != '0) || (st == ST_PRE_EV && post_q_cnt != '0);
    assign tbl_src_o = causal ? pre_q_addr : ev_addr;
    assign tbl_dst_o = causal ? ev_addr : post_q_addr;
    assign tbl_we_o  = tbl_req_o && tbl_hit_i;

    stdp_tq_update #(.W_W(W_W), .CNT_W(CNT_W)) upd_i (
        .w_i(tbl_rdata_i), .amt_i(amt), .up_i(causal), .w_o(tbl_wdata_o)
    );

    // R8
    evt_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (post_acc || pre_acc) |=> !rdy_o);
    // R8
    tick_idle_chk: assert property (@(posedge clk) disable iff (rst)
        tick_acc |=> rdy_o);
    // R3
    pot_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (tbl_we_o && st == ST_POST_EV) |-> tbl_wdata_o >= tbl_rdata_i);
    // R4
    dep_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (tbl_we_o && st == ST_PRE_EV) |-> tbl_wdata_o <= tbl_rdata_i);
    // R1
    idle_access_chk: assert property (@(posedge clk) disable iff (rst)
        rdy_o |-> !tbl_req_o);

endmodule

// File: tb/stdp_tq_engine_tb_top.sv
module stdp_tq_engine_tb_top;
    localparam int AW = 3, NN = 8, WW = 5, DP = 4, TP = 3, TM = 5, WMAX = 31;

    logic clk = 0, rst = 1;
    logic tick_vld = 0, post_vld = 0, pre_vld = 0;
    logic [AW-1:0] post_addr = '0, pre_addr = '0;
    logic rdy, tbl_req, tbl_we, tbl_hit;
    logic [AW-1:0] tbl_src, tbl_dst;
    logic [WW-1:0] tbl_rdata, tbl_wdata;

    logic [WW-1:0] mem [NN][NN];
    bit            ex  [NN][NN];
    int            expw[NN][NN];
    int qpc[DP], qpa[DP], qoc[DP], qoa[DP], ppre, ppost;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    stdp_tq_engine #(.ADDR_W(AW), .W_W(WW), .DEPTH(DP), .TAU_PLUS(TP), .TAU_MINUS(TM)) dut_i (
        .clk(clk), .rst(rst), .tick_vld_i(tick_vld), .post_vld_i(post_vld), .post_addr_i(post_addr),
        .pre_vld_i(pre_vld), .pre_addr_i(pre_addr), .rdy_o(rdy), .tbl_req_o(tbl_req),
        .tbl_src_o(tbl_src), .tbl_dst_o(tbl_dst), .tbl_rdata_i(tbl_rdata), .tbl_hit_i(tbl_hit),
        .tbl_we_o(tbl_we), .tbl_wdata_o(tbl_wdata));

    assign tbl_rdata = mem[tbl_src][tbl_dst];
    assign tbl_hit   = ex[tbl_src][tbl_dst];
    always @(posedge clk) if (tbl_we) mem[tbl_src][tbl_dst] <= tbl_wdata;

    task automatic chk(input string req, input int act, input int exv);
        checks++;
        if (act != exv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exv);
        end
    endtask

    task automatic cmp_table(input string req);
        int bad = -1;
        for (int s = 0; s < NN; s++)
            for (int d = 0; d < NN; d++)
                if (bad < 0 && int'(mem[s][d]) != expw[s][d]) bad = s * NN + d;
        if (bad < 0) chk(req, 0, 0);
        else chk(req, int'(mem[bad / NN][bad % NN]), expw[bad / NN][bad % NN]);
    endtask

    function automatic int sat(input int v);
        return v < 0 ? 0 : (v > WMAX ? WMAX : v);
    endfunction

    task automatic m_tick();
        for (int i = 0; i < DP; i++) begin
            if (qpc[i] > 0) qpc[i]--;
            if (qoc[i] > 0) qoc[i]--;
        end
    endtask

    task automatic m_post(input int a);
        for (int i = 0; i < DP; i++)
            if (qpc[i] > 0 && ex[qpa[i]][a]) expw[qpa[i]][a] = sat(expw[qpa[i]][a] + qpc[i]);
        qoc[ppost] = TM; qoa[ppost] = a; ppost = (ppost + 1) % DP;
    endtask

    task automatic m_pre(input int a);
        for (int i = 0; i < DP; i++)
            if (qoc[i] > 0 && ex[a][qoa[i]]) expw[a][qoa[i]] = sat(expw[a][qoa[i]] - qoc[i]);
        qpc[ppre] = TP; qpa[ppre] = a; ppre = (ppre + 1) % DP;
    endtask

    task automatic send(input bit t, input bit po, input bit pr, input int pa, input int ra);
        while (!rdy) @(negedge clk);
        tick_vld = t; post_vld = po; pre_vld = pr;
        post_addr = AW'(pa); pre_addr = AW'(ra);
        while (tick_vld || post_vld || pre_vld) begin
            while (!rdy) @(negedge clk);
            @(negedge clk);
            if (tick_vld) begin tick_vld = 0; m_tick(); end
            else if (post_vld) begin post_vld = 0; m_post(pa); end
            else begin pre_vld = 0; m_pre(ra); end
        end
        while (!rdy) @(negedge clk);
    endtask

    task automatic set_w(input int s, input int d, input int w, input bit e);
        mem[s][d] = WW'(w); expw[s][d] = w; ex[s][d] = e;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int busy;
        void'($urandom(32'd1234));
        ppre = 0; ppost = 0;
        for (int i = 0; i < DP; i++) begin qpc[i] = 0; qoc[i] = 0; qpa[i] = 0; qoa[i] = 0; end
        for (int s = 0; s < NN; s++)
            for (int d = 0; d < NN; d++) set_w(s, d, 8, 1'b1);
        repeat (3) @(negedge clk);
        chk("R1 rdy in reset", rdy, 1);
        chk("R1 req in reset", tbl_req, 0);
        rst = 0;
        @(negedge clk);
        chk("R1 rdy after reset", rdy, 1);
        send(0, 1, 0, 1, 0);
        cmp_table("R1 empty queues");

        send(0, 0, 1, 0, 2); send(1, 0, 0, 0, 0); send(0, 1, 0, 3, 0);
        chk("R3 causal +2", mem[2][3], 10);
        cmp_table("R3");
        send(0, 0, 1, 0, 3);
        chk("R4 anti-causal -5", mem[3][3], 3);
        cmp_table("R4");

        for (int k = 0; k < 6; k++) send(1, 0, 0, 0, 0);
        set_w(4, 5, 30, 1'b1);
        send(0, 0, 1, 0, 4); send(0, 1, 0, 5, 0);
        chk("R5 top saturation", mem[4][5], 31);
        set_w(5, 6, 1, 1'b1);
        send(0, 1, 0, 6, 0); send(0, 0, 1, 0, 5);
        chk("R5 bottom saturation", mem[5][6], 0);
        cmp_table("R5");

        for (int k = 0; k < 6; k++) send(1, 0, 0, 0, 0);
        set_w(6, 7, 8, 1'b0);
        send(0, 0, 1, 0, 6); send(0, 1, 0, 7, 0);
        chk("R6 missing row", mem[6][7], 8);
        cmp_table("R6");

        for (int k = 0; k < 6; k++) send(1, 0, 0, 0, 0);
        for (int s = 0; s < 5; s++) set_w(s, 2, 8, 1'b1);
        for (int s = 0; s < 5; s++) send(0, 0, 1, 0, s);
        send(0, 1, 0, 2, 0);
        chk("R7 oldest overwritten", mem[0][2], 8);
        chk("R7 newest kept", mem[4][2], 11);
        cmp_table("R7");

        for (int k = 0; k < 6; k++) send(1, 0, 0, 0, 0);
        send(0, 0, 1, 0, 1); send(1, 0, 0, 0, 0); send(1, 0, 0, 0, 0); send(1, 0, 0, 0, 0);
        send(0, 1, 0, 4, 0);
        cmp_table("R2 expiry");

        send(1, 1, 1, 6, 1);
        cmp_table("R9 priority");
        send(0, 1, 1, 3, 3);
        cmp_table("R9 post before pre");

        @(negedge clk);
        post_vld = 1; post_addr = 3'd0;
        @(negedge clk);
        post_vld = 0; m_post(0);
        busy = 0;
        while (!rdy) begin busy++; @(negedge clk); end
        chk("R8 busy cycles", busy, DP);
        tick_vld = 1;
        @(negedge clk);
        tick_vld = 0; m_tick();
        chk("R8 tick keeps ready", rdy, 1);
        cmp_table("R8");

        for (int s = 0; s < NN; s++)
            for (int d = 0; d < NN; d++) set_w(s, d, int'($urandom_range(0, 31)), ($urandom_range(0, 9) != 0));
        for (int n = 0; n < 400; n++) begin
            int r = int'($urandom_range(0, 9));
            send(r < 3, r >= 3 && r < 6, r >= 6 || r == 5, int'($urandom_range(0, NN - 1)),
                 int'($urandom_range(0, NN - 1)));
            cmp_table("R3 R4 R5 random");
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule